// File: doc/BRIEF.md
# Pin Port Controller with Four-Way Function Select

This block controls one port of general-purpose pins. Each pin is driven either by the port's own software-controlled logic or by one of four internal functions, named F0 to F3. Every per-pin setting is a one-bit-per-pin state vector. Software changes a vector through two strobe addresses: one that sets the chosen bits and one that clears them. It never has to read a vector and write it back. Bit n of every vector and every write belongs to pin n.

The controller registers the pad drive and the pad attributes: output enable, output value, pull-up, pull-down, input-filter enable and filter mode. It can make any pin open drain. In that mode a high value releases the pad and does not drive it. The divider for the slow filter clock is a plain register. A status address returns the synchronised level of the pads, whoever owns the pins.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is owned by the port logic. The output enable, output value, pull-down, open-drain, filter enable, filter mode, both select vectors and the divider are zero. Pull-up is one on every pin, `pad_pu` is all ones and `pad_oe` is zero.
- R2: Each attribute k has a set strobe at write address 2k and a clear strobe at write address 2k+1. A one bit sets or clears that pin in the next cycle. Zero bits, and writes to any other address, leave the attribute unchanged. The attribute numbers are: 0 = owned by port logic, 1 = output enable, 2 = output value, 3 = pull-up, 4 = pull-down, 5 = open drain, 6 = filter enable, 7 = filter mode (1 = debounce, 0 = glitch), 8 = select low bit, 9 = select high bit.
- R3: A read with `rd_en` high puts the addressed word on `rd_data` at the next clock edge. Address 2k returns attribute k, address 20 returns the divider, address 21 returns the pad level, and any other address returns zero.
- R4: For a pin owned by the port logic with open drain off, `pad_oe` and `pad_out` follow the output-enable and output-value attributes. They take the new value one clock after the attribute changes.
- R5: For a pin that is not owned by the port logic, the function index is {select high bit, select low bit}: 0 = F0, 1 = F1, 2 = F2, 3 = F3. Pin i then takes its enable from `per_oe[f*N+i]` and its value from `per_out[f*N+i]`, registered one clock later.
- R6: When open drain is on for a pin, `pad_out` is 0 and `pad_oe` is high only when the selected source enables the pin and drives it low.
- R7: A set of pull-up clears pull-down on the same pins, and a set of pull-down clears pull-up. `pad_pu` and `pad_pd` are never high together on one pin.
- R8: `pad_filt_en` and `pad_filt_deb` follow filter enable and filter mode one clock later. A write to address 20 loads the low DIVW bits of the data into `filt_div`.
- R9: Address 21 returns `pad_in` after a two-stage synchroniser, whatever owns the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; bit n acts on pin n |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |
| per_oe | input | 4*N | Output enables of functions F0..F3, function f at bits f*N+:N |
| per_out | input | 4*N | Output values of functions F0..F3, same layout |
| pad_in | input | N | Pad levels |
| pad_oe | output | N | Pad output enable |
| pad_out | output | N | Pad output value |
| pad_pu | output | N | Pull-up enable |
| pad_pd | output | N | Pull-down enable |
| pad_filt_en | output | N | Input filter enable |
| pad_filt_deb | output | N | Filter mode, 1 = debounce |
| filt_div | output | DIVW | Slow-clock divider for debounce |

## Verification
The set and clear strobes are driven with overlapping masks and with all-zero masks. This separates a correct per-bit update from whole-word overwrites and from an inverted clear. Four pins are then handed to the functions, one per select code, and each function drives a different one-hot enable. A swapped select bit or a wrong function index therefore shows up on a specific pin. Open-drain pins are mixed with high and low values so that releasing the pad can be told apart from driving it. Crossed pull-up and pull-down sets show the mutual clear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // attribute numbering; set strobe at 2k, clear strobe at 2k+1
  localparam int A_OWN   = 0;
  localparam int A_OE    = 1;
  localparam int A_DOUT  = 2;
  localparam int A_PU    = 3;
  localparam int A_PD    = 4;
  localparam int A_OD    = 5;
  localparam int A_FEN   = 6;
  localparam int A_FMODE = 7;
  localparam int A_SEL0  = 8;
  localparam int A_SEL1  = 9;
  localparam int NUM_ATTR = 10;

  localparam int ADDR_DIV   = 2 * NUM_ATTR;
  localparam int ADDR_LEVEL = ADDR_DIV + 1;

  localparam int NUM_FUNC = 4;
endpackage

// File: rtl/gpio_attr_bank.sv
module gpio_attr_bank #(
  parameter int N = 32,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_m,
  input  logic [N-1:0] clr_m,
  output logic [N-1:0] q
);
  // clear wins over set on the same bit
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int N = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        own,
  input  logic [N-1:0]        sel0,
  input  logic [N-1:0]        sel1,
  input  logic [N-1:0]        od,
  input  logic [N-1:0]        gpio_oe,
  input  logic [N-1:0]        gpio_out,
  input  logic [NUM_FUNC*N-1:0] per_oe,
  input  logic [NUM_FUNC*N-1:0] per_out,
  output logic [N-1:0]        pad_oe,
  output logic [N-1:0]        pad_out
);
  logic [N-1:0] oe_n;
  logic [N-1:0] out_n;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [NUM_FUNC-1:0] f_oe;
    logic [NUM_FUNC-1:0] f_out;
    logic [1:0]          fidx;
    logic                src_oe;
    logic                src_out;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
      assign f_oe[f]  = per_oe[f*N + i];
      assign f_out[f] = per_out[f*N + i];
    end

    assign fidx    = {sel1[i], sel0[i]};
    assign src_oe  = own[i] ? gpio_oe[i]  : f_oe[fidx];
    assign src_out = own[i] ? gpio_out[i] : f_out[fidx];
    // open drain: only a low is driven, a high releases the pad
    assign oe_n[i]  = od[i] ? (src_oe & ~src_out) : src_oe;
    assign out_n[i] = od[i] ? 1'b0 : src_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= oe_n;
      pad_out <= out_n;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int N    = 32,
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int DIVW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data,
  input  logic [NUM_FUNC*N-1:0] per_oe,
  input  logic [NUM_FUNC*N-1:0] per_out,
  input  logic [N-1:0]          pad_in,
  output logic [N-1:0]          pad_oe,
  output logic [N-1:0]          pad_out,
  output logic [N-1:0]          pad_pu,
  output logic [N-1:0]          pad_pd,
  output logic [N-1:0]          pad_filt_en,
  output logic [N-1:0]          pad_filt_deb,
  output logic [DIVW-1:0]       filt_div
);
  logic [N-1:0] st      [NUM_ATTR];
  logic [N-1:0] set_raw [NUM_ATTR];
  logic [N-1:0] clr_raw [NUM_ATTR];
  logic [N-1:0] set_m   [NUM_ATTR];
  logic [N-1:0] clr_m   [NUM_ATTR];
  logic [N-1:0] level_q;
  logic [DW-1:0] rd_mux;

  // named views of the state, also used by the checker
  logic [N-1:0] own_q, oe_q, pu_q, pd_q, od_q;
  assign own_q = st[A_OWN];
  assign oe_q  = st[A_OE];
  assign pu_q  = st[A_PU];
  assign pd_q  = st[A_PD];
  assign od_q  = st[A_OD];

  // strobe decode
  always_comb begin
    for (int k = 0; k < NUM_ATTR; k++) begin
      set_raw[k] = (wr_en && wr_addr == AW'(2*k))     ? wr_data[N-1:0] : '0;
      clr_raw[k] = (wr_en && wr_addr == AW'(2*k + 1)) ? wr_data[N-1:0] : '0;
    end
  end

  // pull-up and pull-down exclude each other
  always_comb begin
    for (int k = 0; k < NUM_ATTR; k++) begin
      set_m[k] = set_raw[k];
      if (k == A_PU)      clr_m[k] = clr_raw[k] | set_raw[A_PD];
      else if (k == A_PD) clr_m[k] = clr_raw[k] | set_raw[A_PU];
      else                clr_m[k] = clr_raw[k];
    end
  end

  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
    localparam logic [N-1:0] RV = (k == A_OWN || k == A_PU) ? {N{1'b1}} : {N{1'b0}};
    gpio_attr_bank #(.N(N), .RST_VAL(RV)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .set_m (set_m[k]),
      .clr_m (clr_m[k]),
      .q     (st[k])
    );
  end

  // divider
  always_ff @(posedge clk) begin
    if (rst) filt_div <= '0;
    else if (wr_en && wr_addr == AW'(ADDR_DIV)) filt_div <= wr_data[DIVW-1:0];
  end

  // pad attributes, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_pu       <= '1;
      pad_pd       <= '0;
      pad_filt_en  <= '0;
      pad_filt_deb <= '0;
    end else begin
      pad_pu       <= st[A_PU];
      pad_pd       <= st[A_PD];
      pad_filt_en  <= st[A_FEN];
      pad_filt_deb <= st[A_FMODE];
    end
  end

  gpio_pin_mux #(.N(N)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .own      (st[A_OWN]),
    .sel0     (st[A_SEL0]),
    .sel1     (st[A_SEL1]),
    .od       (st[A_OD]),
    .gpio_oe  (st[A_OE]),
    .gpio_out (st[A_DOUT]),
    .per_oe   (per_oe),
    .per_out  (per_out),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out)
  );

  gpio_level_sync #(.N(N), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (level_q)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_ATTR; k++)
      if (rd_addr == AW'(2*k)) rd_mux = DW'(st[k]);
    if (rd_addr == AW'(ADDR_DIV))   rd_mux = DW'(filt_div);
    if (rd_addr == AW'(ADDR_LEVEL)) rd_mux = DW'(level_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [N-1:0]  own_q,
  input logic [N-1:0]  oe_q,
  input logic [N-1:0]  pu_q,
  input logic [N-1:0]  pd_q,
  input logic [N-1:0]  od_q,
  input logic [N-1:0]  pad_oe,
  input logic [N-1:0]  pad_out,
  input logic [N-1:0]  pad_pu,
  input logic [N-1:0]  pad_pd
);
  localparam logic [AW-1:0] OE_SET = AW'(2*A_OE);
  localparam logic [AW-1:0] OE_CLR = AW'(2*A_OE + 1);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (own_q == '1 && pu_q == '1 && oe_q == '0 && pd_q == '0)); // R1

  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OE_SET) |=>
      ((oe_q & $past(wr_data[N-1:0])) == $past(wr_data[N-1:0]))); // R2

  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OE_CLR) |=> ((oe_q & $past(wr_data[N-1:0])) == '0)); // R2

  AST_OTHER_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (wr_addr != OE_SET && wr_addr != OE_CLR)) |=> $stable(oe_q)); // R2

  AST_PULL_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pu_q & pd_q) == '0); // R7

  AST_PULL_PAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & pad_out & $past(od_q)) == '0)); // R6
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .own_q   (own_q),
  .oe_q    (oe_q),
  .pu_q    (pu_q),
  .pd_q    (pd_q),
  .od_q    (od_q),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .pad_pu  (pad_pu),
  .pad_pd  (pad_pd)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  localparam int N = 32, AW = 5, DW = 32, DIVW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [4*N-1:0] per_oe = '0, per_out = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe, pad_out, pad_pu, pad_pd, pad_filt_en, pad_filt_deb;
  logic [DIVW-1:0] filt_div;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.N(N), .AW(AW), .DW(DW), .DIVW(DIVW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .per_oe(per_oe), .per_out(per_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_filt_en(pad_filt_en), .pad_filt_deb(pad_filt_deb), .filt_div(filt_div)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [DW-1:0] exp; string req; } exp_t;
  exp_t sb [$];

  // model of the attribute state, built from the requirements
  logic [N-1:0] m [10];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 20) begin
      if (a % 2 == 0) begin
        m[a/2] = m[a/2] | d;
        if (a/2 == 3) m[4] = m[4] & ~d;
        if (a/2 == 4) m[3] = m[3] & ~d;
      end else begin
        m[a/2] = m[a/2] & ~d;
      end
    end
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
    exp_t e;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    e.exp = exp; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compares each read result one edge after the strobe
  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 actual=%h expected=no read pending", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, rd_data, e.exp);
      end
    end
  end

  function automatic void exp_pads(output logic [N-1:0] eo, output logic [N-1:0] ev);
    for (int i = 0; i < N; i++) begin
      int f;
      logic so, sv;
      f = {m[9][i], m[8][i]};
      so = m[0][i] ? m[1][i] : per_oe[f*N + i];
      sv = m[0][i] ? m[2][i] : per_out[f*N + i];
      eo[i] = m[5][i] ? (so & ~sv) : so;
      ev[i] = m[5][i] ? 1'b0 : sv;
    end
  endfunction

  task automatic check_pads(input string req);
    logic [N-1:0] eo, ev;
    @(negedge clk);  // one extra edge for the registered pad outputs
    exp_pads(eo, ev);
    check({req, " pad_oe"}, pad_oe, eo);
    check({req, " pad_out"}, pad_out, ev);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    m[0] = '1; m[3] = '1;
    m[1] = '0; m[2] = '0; m[4] = '0; m[5] = '0;
    m[6] = '0; m[7] = '0; m[8] = '0; m[9] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pad_pu", pad_pu, '1);
    check("R1 pad_oe", pad_oe, '0);
    rd(0,  32'hFFFF_FFFF, "R1 own");
    rd(2,  32'h0, "R1 oe");
    rd(6,  32'hFFFF_FFFF, "R1 pull-up");
    rd(8,  32'h0, "R1 pull-down");
    rd(20, 32'h0, "R1 divider");

    // R2 set/clear with overlapping masks, zero mask
    wr(2, 32'h0000_00F0);
    wr(3, 32'h0000_0030);
    rd(2, 32'h0000_00C0, "R2 oe set then clear");
    wr(4, 32'hA5A5_0000);
    wr(5, 32'h0);
    wr(9, 32'hFFFF_FFFF);  // other attribute: oe untouched
    rd(4, 32'hA5A5_0000, "R2 dout zero-mask clear");
    rd(2, 32'h0000_00C0, "R2 oe after unrelated write");
    rd(30, 32'h0, "R3 unmapped address");

    // R4 port-owned drive
    wr(2, 32'hFFFF_0000);
    check_pads("R4");

    // R6 open drain on pins 16..23
    wr(10, 32'h00FF_0000);
    check_pads("R6");
    check("R6 od pins never driven high", pad_out & 32'h00FF_0000, 32'h0);

    // R5 function select on pins 0..3: F0, F1, F2, F3
    for (int f = 0; f < 4; f++) begin
      per_oe[f*N +: N]  = N'(1) << f;
      per_out[f*N +: N] = N'(1) << f;
    end
    wr(1,  32'h0000_000F);
    wr(16, 32'h0000_000A);
    wr(18, 32'h0000_000C);
    check_pads("R5 four codes");
    check("R5 pins0-3 enabled", pad_oe & 32'hF, 32'hF);
    wr(17, 32'h0000_0002);  // pin1 back to F0
    check_pads("R5 reselect");
    wr(10, 32'h0000_0004);  // pin2 open drain, F2 drives high
    check_pads("R6 peripheral released");

    // R7 pull exclusivity
    wr(8, 32'h0000_0003);
    rd(6, 32'hFFFF_FFFC, "R7 pull-up cleared by pull-down");
    rd(8, 32'h0000_0003, "R7 pull-down set");
    wr(6, 32'h0000_0001);
    rd(8, 32'h0000_0002, "R7 pull-down cleared by pull-up");
    @(negedge clk);
    check("R7 pad_pd", pad_pd, 32'h2);
    check("R7 pad_pu", pad_pu, 32'hFFFF_FFFD);

    // R8 filter
    wr(12, 32'h0000_0100);
    wr(14, 32'h0000_0300);
    wr(20, 32'hFFFF_ABCD);
    @(negedge clk);
    check("R8 filt_en", pad_filt_en, 32'h100);
    check("R8 filt_deb", pad_filt_deb, 32'h300);
    check("R8 filt_div", 32'(filt_div), 32'hABCD);
    rd(20, 32'h0000_ABCD, "R8 divider readback");
    rd(14, 32'h0000_0300, "R3 filter mode readback");

    // R9 pad level, pins partly peripheral-owned
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd(21, 32'hDEAD_BEEF, "R9 pad level");
    pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(21, 32'h1234_5678, "R9 pad level change");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R3 actual=%0d pending expected=0 pending", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule